// File: doc/BRIEF.md
# Load-Store Address Generation and Load Extension Unit

This unit sits between the integer register file and the data-memory port of a 64-bit core. For each load or store it takes a base value and an offset and forms the access address. The offset is either a signed immediate or a register value. A register value may be used whole, or its low 32 bits may be widened by zero or sign extension, and it may then be shifted left by a scale amount. Three indexing modes are supported: plain offset, pre-index and post-index. Both pre-index and post-index produce a base-writeback value. Pair transfers also get a second address, one element further on.

The address, size, write flag, pair flag and writeback result are captured in one register stage. They appear as a request one cycle after the inputs are accepted. A separate combinational path takes raw data returned by memory and shapes it for the destination register. Byte, half-word, word or double-word data is zero-extended or sign-extended, to 32 or 64 bits.

Top module: `ldst_agen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `mreq_valid_o` and `wb_en_o` are 0.
- R2: With `off_sel_i`=0 the offset is `imm_i` sign-extended from IMM_W bits and is never shifted. In plain mode (`idx_mode_i`=0, or the unused code 3) the address is base plus offset and `wb_en_o` is 0.
- R3: With `off_sel_i`=1 the register offset is widened according to `ext_mode_i`. Code 1 zero-extends bits 31:0. Code 2 sign-extends bits 31:0. Codes 0 and 3 use all 64 bits.
- R4: The widened register offset is shifted left by `shamt_i` before it is added to the base.
- R5: In pre-index mode (`idx_mode_i`=1) the address equals base plus offset. `wb_en_o` is 1 and `wb_val_o` equals that same address.
- R6: In post-index mode (`idx_mode_i`=2) the address equals the unmodified base. `wb_en_o` is 1 and `wb_val_o` equals base plus offset.
- R7: `mreq_addr2_o` equals `mreq_addr_o` plus 2 to the power `size_i` bytes. The size codes are 0=1, 1=2, 2=4, 3=8 and 4=16 bytes. `mreq_pair_o`, `mreq_size_o` and `mreq_we_o` repeat `pair_i`, `size_i` and `store_i` of the accepted request.
- R8: `mreq_valid_o` equals `req_valid_i` of the previous clock edge. All request fields reflect the inputs present at that edge.
- R9: With `ld_signed_i`=0 the loaded element is zero-extended. `ld_size_i` selects the element: 0=bits 7:0, 1=15:0, 2=31:0, 3=63:0.
- R10: With `ld_signed_i`=1, byte, half-word and word elements are sign-extended. For raw byte 0x8A, a 32-bit destination reads 0x00000000FFFFFF8A and a 64-bit destination reads 0xFFFFFFFFFFFFFF8A.
- R11: With `ld_dst64_i`=0, bits 63:32 of `ld_data_o` are 0 for every element size, including double-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| base_i | input | 64 | Base register value |
| off_sel_i | input | 1 | 0 = immediate offset, 1 = register offset |
| imm_i | input | 12 | Signed immediate offset |
| reg_off_i | input | 64 | Register offset value |
| ext_mode_i | input | 2 | Register offset widening: 0/3 none, 1 zero, 2 sign |
| shamt_i | input | 3 | Left shift applied to register offset |
| idx_mode_i | input | 2 | 0/3 plain, 1 pre-index, 2 post-index |
| size_i | input | 3 | Log2 of access size in bytes (0..4) |
| store_i | input | 1 | 1 = store, 0 = load |
| pair_i | input | 1 | Pair transfer |
| mreq_valid_o | output | 1 | Registered request valid |
| mreq_addr_o | output | 64 | Access address |
| mreq_addr2_o | output | 64 | Second element address for pairs |
| mreq_size_o | output | 3 | Registered size code |
| mreq_we_o | output | 1 | Registered write enable |
| mreq_pair_o | output | 1 | Registered pair flag |
| wb_en_o | output | 1 | Base writeback required |
| wb_val_o | output | 64 | New base value |
| ld_raw_i | input | 64 | Raw data returned from memory |
| ld_size_i | input | 2 | Loaded element size: 0 B, 1 H, 2 W, 3 D |
| ld_signed_i | input | 1 | Sign-extend loaded element |
| ld_dst64_i | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| ld_data_o | output | 64 | Shaped load result |

## Verification
Directed vectors place a negative immediate next to a register offset whose low word has bit 31 set. The result shows whether zero and sign widening were swapped, and whether the shift was wrongly applied to the immediate. Each of the three index modes runs with the same base and offset, so a swap between the access address and the writeback value shows at once. Load shaping is tried with the byte 0x8A and with all-ones words, for every size, both sign settings and both destination widths. This separates a 32-bit from a 64-bit sign fill and catches leakage into the upper word. A long run of mixed pseudo-random requests then checks pair steps of 1 to 16 bytes and back-to-back valid timing.

// File: rtl/ldst_agen_pkg.sv
// Shared encodings for the load-store address unit.
// Assumes 2-bit mode fields; unused codes fall back to the plain behaviour.
package ldst_agen_pkg;
    typedef enum logic [1:0] {
        IDX_PLAIN = 2'd0,
        IDX_PRE   = 2'd1,
        IDX_POST  = 2'd2,
        IDX_RSVD  = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        WID_FULL  = 2'd0,
        WID_ZERO  = 2'd1,
        WID_SIGN  = 2'd2,
        WID_RSVD  = 2'd3
    } widen_e;

    localparam int unsigned NUM_LD_SIZES = 4;
endpackage

// File: rtl/ldst_offset_gen.sv
// Forms the offset added to the base: a sign-extended immediate, or a
// register value widened from its low half and shifted left.
// Assumes XLEN is even and larger than IMM_W.
module ldst_offset_gen #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned IMM_W = 12,
    parameter int unsigned SH_W  = 3
) (
    input  logic            off_sel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0] reg_off_i,
    input  logic [1:0]      ext_mode_i,
    input  logic [SH_W-1:0] shamt_i,
    output logic [XLEN-1:0] offset_o
);
    import ldst_agen_pkg::*;
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] reg_wide;
    logic [XLEN-1:0] reg_scaled;

    // Sign-extend the immediate to full width.
    always_comb imm_wide = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

    // Widen the register offset as the extension mode asks.
    always_comb begin
        unique case (widen_e'(ext_mode_i))
            WID_ZERO: reg_wide = {{HALF{1'b0}}, reg_off_i[HALF-1:0]};
            WID_SIGN: reg_wide = {{HALF{reg_off_i[HALF-1]}}, reg_off_i[HALF-1:0]};
            default:  reg_wide = reg_off_i;
        endcase
    end

    // Scale the register offset; immediates stay unscaled.
    always_comb reg_scaled = reg_wide << shamt_i;

    // Pick the offset source.
    always_comb offset_o = off_sel_i ? reg_scaled : imm_wide;
endmodule

// File: rtl/ldst_addr_calc.sv
// Computes access address, pair address and writeback value from base and
// offset according to the indexing mode. Purely combinational.
module ldst_addr_calc #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned SIZE_W = 3
) (
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   offset_i,
    input  logic [1:0]        idx_mode_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [XLEN-1:0]   addr_o,
    output logic [XLEN-1:0]   addr2_o,
    output logic              wb_en_o,
    output logic [XLEN-1:0]   wb_val_o
);
    import ldst_agen_pkg::*;

    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] step;

    // Base plus offset, shared by address and writeback.
    always_comb sum = base_i + offset_i;

    // Element stride in bytes for the second pair address.
    always_comb step = {{(XLEN-1){1'b0}}, 1'b1} << size_i;

    // Select address and writeback by indexing mode.
    always_comb begin
        unique case (idx_mode_e'(idx_mode_i))
            IDX_PRE: begin
                addr_o  = sum;
                wb_en_o = 1'b1;
            end
            IDX_POST: begin
                addr_o  = base_i;
                wb_en_o = 1'b1;
            end
            default: begin
                addr_o  = sum;
                wb_en_o = 1'b0;
            end
        endcase
        wb_val_o = sum;
    end

    // Second address of a pair transfer.
    always_comb addr2_o = addr_o + step;
endmodule

// File: rtl/ldst_load_shaper.sv
// Extracts a byte, half-word, word or double-word from returned data and
// zero- or sign-extends it; a 32-bit destination clears the upper half.
module ldst_load_shaper #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] raw_i,
    input  logic [1:0]      size_i,
    input  logic            signed_i,
    input  logic            dst64_i,
    output logic [XLEN-1:0] data_o
);
    import ldst_agen_pkg::*;
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] cand [NUM_LD_SIZES];
    logic [XLEN-1:0] picked;

    // One extended candidate per element size.
    for (genvar g = 0; g < NUM_LD_SIZES; g++) begin : g_size
        localparam int unsigned EW = 8 << g;
        if (EW < XLEN) begin : g_ext
            logic fill;
            assign fill    = signed_i & raw_i[EW-1];
            assign cand[g] = {{(XLEN-EW){fill}}, raw_i[EW-1:0]};
        end else begin : g_full
            assign cand[g] = raw_i;
        end
    end

    // Choose the candidate for the requested size.
    always_comb picked = cand[size_i];

    // Narrow destinations keep only the low half.
    always_comb data_o = dst64_i ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};
endmodule

// File: rtl/ldst_agen.sv
// Top of the load-store address unit. Registers one request per accepted
// input cycle; the load shaping path is combinational.
// Assumes the memory side consumes the request the cycle it is valid.
module ldst_agen #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned IMM_W  = 12,
    parameter int unsigned SH_W   = 3,
    parameter int unsigned SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic              off_sel_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [XLEN-1:0]   reg_off_i,
    input  logic [1:0]        ext_mode_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [1:0]        idx_mode_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              store_i,
    input  logic              pair_i,
    output logic              mreq_valid_o,
    output logic [XLEN-1:0]   mreq_addr_o,
    output logic [XLEN-1:0]   mreq_addr2_o,
    output logic [SIZE_W-1:0] mreq_size_o,
    output logic              mreq_we_o,
    output logic              mreq_pair_o,
    output logic              wb_en_o,
    output logic [XLEN-1:0]   wb_val_o,
    input  logic [XLEN-1:0]   ld_raw_i,
    input  logic [1:0]        ld_size_i,
    input  logic              ld_signed_i,
    input  logic              ld_dst64_i,
    output logic [XLEN-1:0]   ld_data_o
);
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] addr2_c;
    logic            wb_en_c;
    logic [XLEN-1:0] wb_val_c;

    ldst_offset_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
        .off_sel_i  (off_sel_i),
        .imm_i      (imm_i),
        .reg_off_i  (reg_off_i),
        .ext_mode_i (ext_mode_i),
        .shamt_i    (shamt_i),
        .offset_o   (offset)
    );

    ldst_addr_calc #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_addr (
        .base_i     (base_i),
        .offset_i   (offset),
        .idx_mode_i (idx_mode_i),
        .size_i     (size_i),
        .addr_o     (addr_c),
        .addr2_o    (addr2_c),
        .wb_en_o    (wb_en_c),
        .wb_val_o   (wb_val_c)
    );

    ldst_load_shaper #(.XLEN(XLEN)) u_shape (
        .raw_i    (ld_raw_i),
        .size_i   (ld_size_i),
        .signed_i (ld_signed_i),
        .dst64_i  (ld_dst64_i),
        .data_o   (ld_data_o)
    );

    // Valid and writeback-enable stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_valid_o <= 1'b0;
            wb_en_o      <= 1'b0;
        end else begin
            mreq_valid_o <= req_valid_i;
            wb_en_o      <= req_valid_i & wb_en_c;
        end
    end

    // Request payload stage, loaded on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_addr_o  <= '0;
            mreq_addr2_o <= '0;
            mreq_size_o  <= '0;
            mreq_we_o    <= 1'b0;
            mreq_pair_o  <= 1'b0;
            wb_val_o     <= '0;
        end else if (req_valid_i) begin
            mreq_addr_o  <= addr_c;
            mreq_addr2_o <= addr2_c;
            mreq_size_o  <= size_i;
            mreq_we_o    <= store_i;
            mreq_pair_o  <= pair_i;
            wb_val_o     <= wb_val_c;
        end
    end
endmodule

// File: rtl/ldst_agen_chk.sv
// Property checker for ldst_agen, attached by bind below.
module ldst_agen_chk #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [XLEN-1:0]   base_i,
    input logic [1:0]        idx_mode_i,
    input logic              mreq_valid_o,
    input logic [XLEN-1:0]   mreq_addr_o,
    input logic [XLEN-1:0]   mreq_addr2_o,
    input logic [SIZE_W-1:0] mreq_size_o,
    input logic              mreq_pair_o,
    input logic              wb_en_o,
    input logic [XLEN-1:0]   wb_val_o,
    input logic              ld_dst64_i,
    input logic [XLEN-1:0]   ld_data_o
);
    logic armed;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (mreq_valid_o == $past(req_valid_i)));

    // R2
    plain_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid_i && (idx_mode_i == 2'd0))) |-> !wb_en_o);

    // R5
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid_i && (idx_mode_i == 2'd1))) |-> (wb_en_o && mreq_addr_o == wb_val_o));

    // R6
    post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid_i && (idx_mode_i == 2'd2))) |-> (wb_en_o && mreq_addr_o == $past(base_i)));

    // R7
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid_o && mreq_pair_o) |-> ((mreq_addr2_o - mreq_addr_o) == ({{(XLEN-1){1'b0}}, 1'b1} << mreq_size_o)));

    // R11
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_dst64_i |-> (ld_data_o[XLEN-1:XLEN/2] == '0));
endmodule

bind ldst_agen ldst_agen_chk #(.XLEN(XLEN), .SIZE_W(SIZE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .base_i       (base_i),
    .idx_mode_i   (idx_mode_i),
    .mreq_valid_o (mreq_valid_o),
    .mreq_addr_o  (mreq_addr_o),
    .mreq_addr2_o (mreq_addr2_o),
    .mreq_size_o  (mreq_size_o),
    .mreq_pair_o  (mreq_pair_o),
    .wb_en_o      (wb_en_o),
    .wb_val_o     (wb_val_o),
    .ld_dst64_i   (ld_dst64_i),
    .ld_data_o    (ld_data_o)
);

// File: tb/ldst_agen_tb_top.sv
// Bench: behavioural reference model, compared every cycle.
module ldst_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid_i;
    logic [63:0] base_i;
    logic        off_sel_i;
    logic [11:0] imm_i;
    logic [63:0] reg_off_i;
    logic [1:0]  ext_mode_i;
    logic [2:0]  shamt_i;
    logic [1:0]  idx_mode_i;
    logic [2:0]  size_i;
    logic        store_i;
    logic        pair_i;
    logic        mreq_valid_o;
    logic [63:0] mreq_addr_o;
    logic [63:0] mreq_addr2_o;
    logic [2:0]  mreq_size_o;
    logic        mreq_we_o;
    logic        mreq_pair_o;
    logic        wb_en_o;
    logic [63:0] wb_val_o;
    logic [63:0] ld_raw_i;
    logic [1:0]  ld_size_i;
    logic        ld_signed_i;
    logic        ld_dst64_i;
    logic [63:0] ld_data_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ldst_agen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .base_i(base_i),
        .off_sel_i(off_sel_i), .imm_i(imm_i), .reg_off_i(reg_off_i),
        .ext_mode_i(ext_mode_i), .shamt_i(shamt_i), .idx_mode_i(idx_mode_i),
        .size_i(size_i), .store_i(store_i), .pair_i(pair_i),
        .mreq_valid_o(mreq_valid_o), .mreq_addr_o(mreq_addr_o),
        .mreq_addr2_o(mreq_addr2_o), .mreq_size_o(mreq_size_o),
        .mreq_we_o(mreq_we_o), .mreq_pair_o(mreq_pair_o),
        .wb_en_o(wb_en_o), .wb_val_o(wb_val_o), .ld_raw_i(ld_raw_i),
        .ld_size_i(ld_size_i), .ld_signed_i(ld_signed_i),
        .ld_dst64_i(ld_dst64_i), .ld_data_o(ld_data_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference offset from the requirement text.
    function automatic logic [63:0] ref_off(bit rsel, logic [11:0] im, logic [63:0] r,
                                            int ext, int sh);
        longint v;
        if (!rsel) return 64'(signed'(im));
        if (ext == 1)      v = longint'(r[31:0]) & 64'h0000_0000_FFFF_FFFF;
        else if (ext == 2) v = longint'(int'(r[31:0]));
        else               v = longint'(r);
        for (int k = 0; k < sh; k++) v = v * 2;
        return 64'(v);
    endfunction

    function automatic logic [63:0] ref_load(logic [63:0] raw, int sz, bit sgn, bit d64);
        logic [63:0] v;
        case (sz)
            0: v = sgn ? 64'(signed'(raw[7:0]))  : 64'(raw[7:0]);
            1: v = sgn ? 64'(signed'(raw[15:0])) : 64'(raw[15:0]);
            2: v = sgn ? 64'(signed'(raw[31:0])) : 64'(raw[31:0]);
            default: v = raw;
        endcase
        if (!d64) v = v & 64'h0000_0000_FFFF_FFFF;
        return v;
    endfunction

    // One request: drive at a falling edge, check one edge later, then idle.
    task automatic req(string tag, logic [63:0] b, bit rsel, logic [11:0] im,
                       logic [63:0] r, int ext, int sh, int idx, int sz, bit st, bit pr);
        logic [63:0] off, sum, a;
        bit wbe;
        @(negedge clk);
        check("R8 idle", {63'd0, mreq_valid_o}, 64'd0);
        req_valid_i = 1'b1; base_i = b; off_sel_i = rsel; imm_i = im;
        reg_off_i = r; ext_mode_i = 2'(ext); shamt_i = 3'(sh);
        idx_mode_i = 2'(idx); size_i = 3'(sz); store_i = st; pair_i = pr;
        off = ref_off(rsel, im, r, ext, sh);
        sum = b + off;
        a   = (idx == 2) ? b : sum;
        wbe = (idx == 1) || (idx == 2);
        @(negedge clk);
        req_valid_i = 1'b0;
        check({tag, " R8 valid"}, {63'd0, mreq_valid_o}, 64'd1);
        check({tag, " addr"}, mreq_addr_o, a);
        check({tag, " wb_en"}, {63'd0, wb_en_o}, {63'd0, wbe});
        if (wbe) check({tag, " wb_val"}, wb_val_o, sum);
        check("R7 addr2", mreq_addr2_o, a + (64'd1 << sz));
        check("R7 fields", {59'd0, mreq_size_o, mreq_we_o, mreq_pair_o},
              {59'd0, 3'(sz), st, pr});
    endtask

    task automatic ld(string tag, logic [63:0] raw, int sz, bit sgn, bit d64);
        ld_raw_i = raw; ld_size_i = 2'(sz); ld_signed_i = sgn; ld_dst64_i = d64;
        #1;
        check(tag, ld_data_o, ref_load(raw, sz, sgn, d64));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid_i = 1'b0; base_i = '0; off_sel_i = 1'b0;
        imm_i = '0; reg_off_i = '0; ext_mode_i = '0; shamt_i = '0;
        idx_mode_i = '0; size_i = '0; store_i = 1'b0; pair_i = 1'b0;
        ld_raw_i = '0; ld_size_i = '0; ld_signed_i = 1'b0; ld_dst64_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, mreq_valid_o}, 64'd0);
        check("R1 wb_en in reset", {63'd0, wb_en_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, mreq_valid_o}, 64'd0);

        // R2: immediate offsets, positive and negative, plain mode
        req("R2 imm+", 64'h1000, 0, 12'h008, 64'hFFFF, 0, 3, 0, 3, 0, 0);
        req("R2 imm-", 64'h1000, 0, 12'hFF8, 64'h0, 0, 7, 0, 3, 1, 0);
        req("R2 rsvd mode", 64'h2000, 0, 12'h010, 64'h0, 0, 0, 3, 2, 0, 0);
        // R3: widening of a register offset with bit 31 set
        req("R3 zero", 64'h1_0000_0000, 1, 12'h0, 64'hAAAA_AAAA_8000_0004, 1, 0, 0, 2, 0, 0);
        req("R3 sign", 64'h1_0000_0000, 1, 12'h0, 64'hAAAA_AAAA_8000_0004, 2, 0, 0, 2, 0, 0);
        req("R3 full", 64'h10, 1, 12'h0, 64'h0000_0002_0000_0000, 0, 0, 0, 3, 0, 0);
        req("R3 rsvd", 64'h10, 1, 12'h0, 64'h0000_0002_0000_0000, 3, 0, 0, 3, 0, 0);
        // R4: scaling of register offsets
        req("R4 sh2", 64'h4000, 1, 12'h0, 64'h5, 0, 2, 0, 2, 0, 0);
        req("R4 sxtw sh3", 64'h4000, 1, 12'h0, 64'hFFFF_FFFF, 2, 3, 0, 3, 0, 0);
        // R5 / R6: same operands, pre then post
        req("R5 pre", 64'h8000, 0, 12'hFF0, 64'h0, 0, 0, 1, 3, 1, 1);
        req("R6 post", 64'h8000, 0, 12'h010, 64'h0, 0, 0, 2, 3, 0, 1);
        req("R6 post reg", 64'h8000, 1, 12'h0, 64'h3, 1, 2, 2, 2, 0, 0);
        // R7: pair strides 4, 8, 16
        req("R7 pair4", 64'hFF0, 0, 12'h0, 64'h0, 0, 0, 0, 2, 0, 1);
        req("R7 pair8", 64'hFF0, 0, 12'h0, 64'h0, 0, 0, 1, 3, 1, 1);
        req("R7 pair16", 64'hFF0, 0, 12'h0, 64'h0, 0, 0, 2, 4, 1, 1);

        // R8: back-to-back requests, checked against a queue of expected addresses
        begin
            logic [63:0] q [$];
            @(negedge clk);
            for (int i = 0; i < 6; i++) begin
                logic [63:0] b = 64'h100 * (i + 1);
                req_valid_i = 1'b1; base_i = b; off_sel_i = 1'b0;
                imm_i = 12'(i); idx_mode_i = 2'd0; size_i = 3'd0;
                store_i = 1'b0; pair_i = 1'b0;
                q.push_back(b + 64'(i));
                @(negedge clk);
                check("R8 b2b valid", {63'd0, mreq_valid_o}, 64'd1);
                check("R8 b2b addr", mreq_addr_o, q.pop_front());
            end
            req_valid_i = 1'b0;
        end

        // R9/R10/R11: load shaping
        ld("R10 byte W signed", 64'h0000_0000_0000_008A, 0, 1, 0);
        check("R10 literal W", ld_data_o, 64'h0000_0000_FFFF_FF8A);
        ld("R10 byte X signed", 64'h0000_0000_0000_008A, 0, 1, 1);
        check("R10 literal X", ld_data_o, 64'hFFFF_FFFF_FFFF_FF8A);
        ld("R9 byte unsigned", 64'hFFFF_FFFF_FFFF_FF8A, 0, 0, 1);
        check("R9 literal", ld_data_o, 64'h0000_0000_0000_008A);
        for (int sz = 0; sz < 4; sz++)
            for (int sg = 0; sg < 2; sg++)
                for (int dw = 0; dw < 2; dw++) begin
                    ld("R9 R10 R11 sweep 1s", 64'hFFFF_FFFF_FFFF_FFFF, sz, sg[0], dw[0]);
                    ld("R9 R10 sweep 7f", 64'h8123_4567_7F6E_7D8C, sz, sg[0], dw[0]);
                end
        ld("R11 dword narrow", 64'hDEAD_BEEF_1234_5678, 3, 1, 0);

        // Mixed pseudo-random requests and loads
        for (int i = 0; i < 300; i++) begin
            logic [63:0] b = {$urandom, $urandom};
            logic [63:0] r = {$urandom, $urandom};
            int rnd = int'($urandom);
            req("R2 R3 R4 R5 R6 R7 rnd", b, rnd[0], 12'($urandom), r,
                rnd[2:1], rnd[5:3], rnd[7:6], int'(rnd[10:8]) % 5, rnd[11], rnd[12]);
            ld("R9 R10 R11 rnd", {$urandom, $urandom}, rnd[14:13], rnd[15], rnd[16]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule